// File: doc/BRIEF.md
# Fractional Sample-Rate Strobe Generator

This block makes a sample-rate strobe out of a faster master tick stream, at a rational ratio. It does not divide by an integer. An accumulator adds a programmed increment on every tick of the selected master source. Whenever the sum reaches the programmed modulus, the modulus is subtracted and a one-cycle strobe is emitted. The average output rate is therefore the tick rate times inc/mod. The rounding error is carried forward instead of discarded, so the strobes spread evenly over time.

Software programs two things. The first is a two-bit source select that picks one of three master tick inputs. The second is a 32-bit ratio word that holds the increment and the modulus, with the modulus stored as modulus minus one. Writing either setting clears the accumulator, which restarts the strobe phase at a known point. A chip carries several copies of this block, and each audio port picks one of them by number. This project implements a single copy.

Top module: `frac_rate_gen`

## Requirements
- R1: After reset the source select is 0, the increment is 0 and the stored modulus control is 0. `rate_stb` is low and stays low until software writes a new setting.
- R2: Source select value s in {0,1,2} makes only `src_tick[s]` count as a master tick. Pulses on the other tick inputs are ignored.
- R3: Source select value 3 is reserved. With it selected, no tick input produces a strobe.
- R4: When `ratio_we` is high, `ratio_in[15:0]` is taken as the increment and `ratio_in[31:16]` as the modulus control. The modulus is the control value plus one, in the range 1 to 65536.
- R5: On a qualifying tick with increment below the modulus, the accumulator becomes acc+inc. If that sum is at least the modulus, the modulus is subtracted and `rate_stb` is high for exactly the next clock cycle. Otherwise `rate_stb` is low in that cycle.
- R6: Starting from a cleared accumulator with increment below the modulus, N qualifying ticks produce exactly floor(inc*N/mod) strobes.
- R7: A cycle with `src_we` or `ratio_we` high clears the accumulator and yields no strobe, even if a tick arrives in that same cycle.
- R8: An increment of zero never produces a strobe.
- R9: An increment equal to or greater than the modulus produces one strobe for every qualifying tick, and the accumulator stays at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | 3 | One-cycle tick pulses from the three master sources |
| src_we | input | 1 | Write strobe for the source select |
| src_sel_in | input | 2 | New source select value |
| ratio_we | input | 1 | Write strobe for the ratio word |
| ratio_in | input | 32 | New ratio word: modulus control [31:16], increment [15:0] |
| rate_stb | output | 1 | One-cycle output sample strobe |

## Verification
Random tick pulses on all three inputs show whether the generator follows only the selected source, and whether it stays silent on the reserved select. Ratios of 3/7, 441/480 and 2/5 under dense and sparse ticks check the exact wrap pattern every cycle and the long-run strobe count. Ratios with inc=0, inc=mod and inc>mod cover the degenerate ends. Writes that land in the same cycle as a tick show that a write clears the accumulator and takes priority over the tick.

// File: rtl/frac_rate_gen.sv
module frac_rate_gen #(
  parameter int W    = 16,
  parameter int NSRC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    src_tick,
  input  logic          src_we,
  input  logic [1:0]    src_sel_in,
  input  logic          ratio_we,
  input  logic [2*W-1:0] ratio_in,
  output logic          rate_stb
);

  logic [1:0]   src_sel;
  logic [W-1:0] inc, modctl, acc;
  logic         sel_tick;
  logic [W:0]   modv, sum, diff;
  logic         wide, hit, cfg_wr;

  always_comb begin
    sel_tick = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (src_sel == 2'(i)) sel_tick = src_tick[i];
  end

  assign cfg_wr = src_we | ratio_we;
  assign modv   = {1'b0, modctl} + 1'b1;
  assign sum    = {1'b0, acc} + {1'b0, inc};
  assign diff   = sum - modv;
  assign wide   = {1'b0, inc} >= modv;
  assign hit    = sum >= modv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_sel  <= '0;
      inc      <= '0;
      modctl   <= '0;
      acc      <= '0;
      rate_stb <= 1'b0;
    end else if (cfg_wr) begin
      if (src_we) src_sel <= src_sel_in;
      if (ratio_we) begin
        inc    <= ratio_in[W-1:0];
        modctl <= ratio_in[2*W-1:W];
      end
      acc      <= '0;
      rate_stb <= 1'b0;
    end else if (sel_tick) begin
      if (wide)     acc <= '0;
      else if (hit) acc <= diff[W-1:0];
      else          acc <= sum[W-1:0];
      rate_stb <= hit | wide;
    end else begin
      rate_stb <= 1'b0;
    end
  end

  // R5
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, acc} < modv);

  // R5
  strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rate_stb |-> $past(sel_tick && !cfg_wr));

  // R7
  wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_wr) |-> (acc == '0 && !rate_stb));

  // R8
  zero_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(inc) == '0) |-> !rate_stb);

  // R3
  reserved_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(src_sel) == 2'd3) |-> !rate_stb);

  // R9
  wide_every_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_tick && !cfg_wr && wide) |=> (rate_stb && acc == '0));

endmodule

// File: tb/tb_frac_rate_gen.sv
module tb_frac_rate_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  src_tick = '0;
  logic        src_we = 1'b0;
  logic [1:0]  src_sel_in = '0;
  logic        ratio_we = 1'b0;
  logic [31:0] ratio_in = '0;
  logic        rate_stb;

  frac_rate_gen dut (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  int m_acc = 0, m_inc = 0, m_mod = 1, m_src = 0;
  int exp_stb = 0;
  int dut_cnt = 0, tick_cnt = 0;
  string req = "R1";
  bit done = 0;

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", r, act, exp, $time);
    end
  endtask

  // drive one cycle (called at negedge), update model, compare at next negedge
  task automatic cyc(input logic [2:0] tk, input bit swe, input logic [1:0] ss,
                     input bit rwe, input logic [31:0] rv);
    src_tick = tk; src_we = swe; src_sel_in = ss; ratio_we = rwe; ratio_in = rv;
    if (swe || rwe) begin
      if (swe) m_src = ss;
      if (rwe) begin m_inc = rv[15:0]; m_mod = rv[31:16] + 1; end
      m_acc = 0; exp_stb = 0;
    end else if (m_src < 3 && tk[m_src]) begin
      tick_cnt++;
      if (m_inc >= m_mod) begin exp_stb = 1; m_acc = 0; end
      else if (m_acc + m_inc >= m_mod) begin exp_stb = 1; m_acc = m_acc + m_inc - m_mod; end
      else begin exp_stb = 0; m_acc = m_acc + m_inc; end
    end else exp_stb = 0;
    @(posedge clk);
    @(negedge clk);
    if (rate_stb) dut_cnt++;
    chk(req, int'(rate_stb), exp_stb);
  endtask

  task automatic run(input int n, input int pct);
    for (int i = 0; i < n; i++) begin
      logic [2:0] t;
      t[0] = ($urandom_range(99) < pct);
      t[1] = ($urandom_range(99) < pct);
      t[2] = ($urandom_range(99) < pct);
      cyc(t, 0, 0, 0, 0);
    end
  endtask

  task automatic set_src(input logic [1:0] s);
    cyc(3'b111, 1, s, 0, 0);
  endtask

  task automatic set_ratio(input int inc, input int modv);
    logic [15:0] mc = 16'(modv - 1);
    cyc(3'b111, 0, 0, 1, {mc, 16'(inc)});
    dut_cnt = 0; tick_cnt = 0;
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1", int'(rate_stb), 0);
    rst_n = 1'b1;
    req = "R1"; run(30, 80);
    chk("R1", dut_cnt, 0);

    req = "R5"; set_src(0); set_ratio(3, 7);
    run(200, 50);
    req = "R6"; chk("R6", dut_cnt, (3 * tick_cnt) / 7);

    req = "R2"; set_src(1); set_ratio(441, 480);
    run(300, 60);
    chk("R6", dut_cnt, (441 * tick_cnt) / 480);

    req = "R4"; set_src(2); set_ratio(2, 5);
    for (int i = 0; i < 5; i++) cyc(3'b100, 0, 0, 0, 0);
    chk("R4", dut_cnt, 2);
    req = "R2"; dut_cnt = 0;
    for (int i = 0; i < 40; i++) cyc(3'b011, 0, 0, 0, 0);
    chk("R2", dut_cnt, 0);

    req = "R3"; set_src(3); dut_cnt = 0;
    run(60, 90);
    chk("R3", dut_cnt, 0);

    req = "R8"; set_src(0); set_ratio(0, 9);
    run(60, 90);
    chk("R8", dut_cnt, 0);

    req = "R9"; set_ratio(5, 5);
    run(60, 50);
    chk("R9", dut_cnt, tick_cnt);
    set_ratio(9, 4);
    run(60, 50);
    chk("R9", dut_cnt, tick_cnt);

    req = "R7"; set_ratio(4, 7);
    for (int k = 0; k < 6; k++) begin
      run(5, 70);
      cyc(3'b111, 0, 0, 1, {16'd6, 16'd4});
      chk("R7", int'(rate_stb), 0);
      cyc(3'b111, 1, 0, 0, 0);
    end
    dut_cnt = 0; tick_cnt = 0;
    run(100, 100);
    chk("R6", dut_cnt, (4 * tick_cnt) / 7);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule